// File: doc/BRIEF.md
# Rotate Unit with Carry

This block rotates a 16-bit or 32-bit operand by a variable count and keeps a one-bit carry flag between operations. It has four modes. Two are plain rotations, left and right, where the carry takes a copy of the last bit carried around the word. The other two rotate through the carry: the flag becomes one more bit of the ring, so the ring is 17 or 33 bits long.

A host presents the operand, mode, width and count and raises the execute enable. The result and the new carry are registered. A done flag is high in the cycle after each execution. In pulse mode, an operation runs only on a rising edge of the enable. In level mode, it runs on every cycle the enable is high. A count outside the legal range for the chosen width raises an error flag and leaves the result and the carry as they were.

Top module: `rot_carry_unit`

## Requirements
- R1: After synchronous reset, result, carry, done and err are all zero.
- R2: With mode = 0 (rotate left) and a legal count n, result is the operand rotated left by n within the selected width, and carry equals result bit 0, which is the last bit carried around.
- R3: With mode = 1 (rotate right) and a legal count n, result is the operand rotated right by n within the selected width, and carry equals the top bit of the selected width.
- R4: With mode = 2 (rotate left through carry), the ring {carry, operand} of width+1 bits is rotated left by n. The low width bits of the ring become result and the top bit of the ring becomes carry.
- R5: With mode = 3 (rotate right through carry), the ring {carry, operand} of width+1 bits is rotated right by n, and is split into result and carry in the same way as in R4.
- R6: When wide = 0 (16-bit), result bits 31..16 are zero after every legal operation. When wide = 1, the width is 32 bits.
- R7: A count of 0, or a count above the selected width (16 or 32), sets err together with done and leaves result and carry unchanged.
- R8: done is high in the cycle after each accepted execution and low in the cycle after any cycle with the enable low.
- R9: With pulse_mode = 1, holding the enable high gives exactly one execution. A new execution needs the enable to fall and rise again.
- R10: With pulse_mode = 0, every cycle with the enable high is an execution, so done stays high.
- R11: A plain rotation whose count equals the width returns the operand unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exec_en | input | 1 | Execute enable |
| pulse_mode | input | 1 | 1: execute on a rising edge of exec_en; 0: execute on every high cycle |
| mode | input | 2 | 0 rotate left, 1 rotate right, 2 left through carry, 3 right through carry |
| wide | input | 1 | 0: 16-bit operand, 1: 32-bit operand |
| count | input | 6 | Rotate count n |
| operand | input | 32 | Data to rotate (low 16 bits used when wide = 0) |
| result | output | 32 | Registered rotated data |
| carry | output | 1 | Registered carry flag |
| done | output | 1 | High in the cycle after an execution |
| err | output | 1 | High with done when the count was illegal |

## Verification
The carry cannot be loaded directly, and the two through-carry modes depend on it. The only way to control the carry-in is through the earlier operations. The sweep therefore chains every mode, width and count, legal and illegal, over several operand patterns without a reset in between. A reference model runs one bit at a time alongside the design and carries its own flag, so the through-carry modes see both carry values many times. Separate sequences hold the enable high for several cycles, in pulse mode and in level mode, to show the difference between one execution per edge and one execution per cycle.

// File: rtl/rot_pkg.sv
package rot_pkg;

    localparam int NARROW_W = 16;
    localparam int WIDE_W   = 32;
    localparam int CNT_W    = 6;
    localparam int LANES    = 2;

    typedef enum logic [1:0] {
        ROT_L = 2'd0,
        ROT_R = 2'd1,
        RTC_L = 2'd2,
        RTC_R = 2'd3
    } rot_mode_e;

    typedef struct packed {
        rot_mode_e          mode;
        logic               wide;
        logic [CNT_W-1:0]   cnt;
        logic [WIDE_W-1:0]  opnd;
        logic               cin;
    } rot_req_t;

    typedef struct packed {
        logic [WIDE_W-1:0]  res;
        logic               cout;
    } rot_rsp_t;

    function automatic logic cnt_legal(input logic wide, input logic [CNT_W-1:0] cnt);
        logic [CNT_W-1:0] lim;
        lim = wide ? CNT_W'(WIDE_W) : CNT_W'(NARROW_W);
        return (cnt != '0) && (cnt <= lim);
    endfunction

endpackage

// File: rtl/rot_trigger.sv
module rot_trigger (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic pulse_mode,
    output logic fire
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) en_q <= 1'b0;
        else     en_q <= en;
    end

    // edge qualifier: level mode passes every high cycle
    assign fire = en & (~pulse_mode | ~en_q);
endmodule

// File: rtl/rot_lane.sv
module rot_lane
    import rot_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 6
) (
    input  rot_mode_e       mode,
    input  logic [CW-1:0]   cnt,
    input  logic [DW-1:0]   x,
    input  logic            cin,
    output logic [DW-1:0]   y,
    output logic            cout
);
    localparam int RL = DW + 1;

    logic [2*DW-1:0] pl_s, pr_s;
    logic [2*RL-1:0] rl_s, rr_s;

    always_comb begin
        pl_s = {x, x} << cnt;
        pr_s = {x, x} >> cnt;
        rl_s = {cin, x, cin, x} << cnt;
        rr_s = {cin, x, cin, x} >> cnt;
        y    = '0;
        cout = 1'b0;
        unique case (mode)
            ROT_L: begin
                y    = pl_s[2*DW-1:DW];
                cout = pl_s[DW];
            end
            ROT_R: begin
                y    = pr_s[DW-1:0];
                cout = pr_s[DW-1];
            end
            RTC_L: {cout, y} = rl_s[2*RL-1:RL];
            RTC_R: {cout, y} = rr_s[RL-1:0];
            default: ;
        endcase
    end
endmodule

// File: rtl/rot_carry_unit.sv
module rot_carry_unit
    import rot_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec_en,
    input  logic              pulse_mode,
    input  logic [1:0]        mode,
    input  logic              wide,
    input  logic [CNT_W-1:0]  count,
    input  logic [WIDE_W-1:0] operand,
    output logic [WIDE_W-1:0] result,
    output logic              carry,
    output logic              done,
    output logic              err
);
    rot_req_t          req;
    rot_rsp_t          rsp;
    logic              fire;
    logic              legal;
    logic [WIDE_W-1:0] lane_y [LANES];
    logic              lane_c [LANES];

    assign req.mode = rot_mode_e'(mode);
    assign req.wide = wide;
    assign req.cnt  = count;
    assign req.opnd = operand;
    assign req.cin  = carry;

    rot_trigger trig_i (
        .clk        (clk),
        .rst        (rst),
        .en         (exec_en),
        .pulse_mode (pulse_mode),
        .fire       (fire)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? NARROW_W : WIDE_W;
        logic [LW-1:0] y_n;
        logic          c_n;
        rot_lane #(.DW(LW), .CW(CNT_W)) lane_i (
            .mode (req.mode),
            .cnt  (req.cnt),
            .x    (req.opnd[LW-1:0]),
            .cin  (req.cin),
            .y    (y_n),
            .cout (c_n)
        );
        assign lane_y[g] = WIDE_W'(y_n);
        assign lane_c[g] = c_n;
    end

    assign rsp.res  = req.wide ? lane_y[1] : lane_y[0];
    assign rsp.cout = req.wide ? lane_c[1] : lane_c[0];
    assign legal    = cnt_legal(req.wide, req.cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            carry  <= 1'b0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= fire;
            err  <= fire & ~legal;
            if (fire && legal) begin
                result <= rsp.res;
                carry  <= rsp.cout;
            end
        end
    end
endmodule

// File: rtl/rot_carry_chk.sv
module rot_carry_chk (
    input logic        clk,
    input logic        rst,
    input logic        exec_en,
    input logic        pulse_mode,
    input logic        wide,
    input logic [31:0] result,
    input logic        carry,
    input logic        done,
    input logic        err
);
    logic en_prev;
    always_ff @(posedge clk) begin
        if (rst) en_prev <= 1'b0;
        else     en_prev <= exec_en;
    end

    // R10
    level_done_chk: assert property (@(posedge clk) disable iff (rst)
        exec_en && !pulse_mode |=> done);

    // R9
    pulse_once_chk: assert property (@(posedge clk) disable iff (rst)
        exec_en && pulse_mode && en_prev |=> !done);

    // R8
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> !done);

    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> $stable(result) && $stable(carry));

    // R7
    err_done_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

    // R6
    narrow_upper_chk: assert property (@(posedge clk) disable iff (rst)
        done && !err && !$past(wide) |-> result[31:16] == 16'h0);
endmodule

bind rot_carry_unit rot_carry_chk chk_i (.*);

// File: tb/rot_carry_unit_test.sv
module rot_carry_unit_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exec_en = 1'b0;
    logic        pulse_mode = 1'b0;
    logic [1:0]  mode = 2'd0;
    logic        wide = 1'b0;
    logic [5:0]  count = 6'd1;
    logic [31:0] operand = '0;
    logic [31:0] result;
    logic        carry, done, err;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_res = '0;
    logic        exp_c = 1'b0;

    always #5 clk = ~clk;

    rot_carry_unit uut (
        .clk(clk), .rst(rst), .exec_en(exec_en), .pulse_mode(pulse_mode),
        .mode(mode), .wide(wide), .count(count), .operand(operand),
        .result(result), .carry(carry), .done(done), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // one bit per step reference
    task automatic ref_rot(input int md, input int w, input int n, input logic [31:0] x,
                           input logic ci, output logic [31:0] r, output logic co);
        logic [32:0] ring;
        logic b;
        int len;
        ring = '0;
        b = ci;
        len = w + ((md >= 2) ? 1 : 0);
        for (int i = 0; i < w; i++) ring[i] = x[i];
        if (md >= 2) ring[w] = ci;
        for (int s = 0; s < n; s++) begin
            if (md == 0 || md == 2) begin
                b = ring[len-1];
                for (int j = len - 1; j > 0; j--) ring[j] = ring[j-1];
                ring[0] = b;
            end else begin
                b = ring[0];
                for (int j = 0; j < len - 1; j++) ring[j] = ring[j+1];
                ring[len-1] = b;
            end
        end
        r = '0;
        for (int i = 0; i < w; i++) r[i] = ring[i];
        co = (md >= 2) ? ring[w] : b;
    endtask

    task automatic do_op(input int md, input int w, input int n, input logic [31:0] x);
        logic [31:0] r;
        logic co;
        string tag;
        @(negedge clk);
        mode = md[1:0]; wide = (w == 32); count = n[5:0]; operand = x;
        pulse_mode = 1'b0; exec_en = 1'b1;
        @(negedge clk);
        exec_en = 1'b0;
        check("R8 done", {31'b0, done}, 32'd1);
        if (n < 1 || n > w) begin
            check("R7 err", {31'b0, err}, 32'd1);
            check("R7 result held", result, exp_res);
            check("R7 carry held", {31'b0, carry}, {31'b0, exp_c});
        end else begin
            ref_rot(md, w, n, x, exp_c, r, co);
            exp_res = r; exp_c = co;
            case (md)
                0: tag = "R2";
                1: tag = "R3";
                2: tag = "R4";
                default: tag = "R5";
            endcase
            check({tag, " result"}, result, exp_res);
            check({tag, " carry"}, {31'b0, carry}, {31'b0, exp_c});
            check({tag, " err"}, {31'b0, err}, 32'd0);
            if (w == 16) check("R6 upper zero", {16'b0, result[31:16]}, 32'd0);
            if (n == w && md < 2) begin
                // R11
                check("R11 full turn", result, (w == 16) ? {16'b0, x[15:0]} : x);
            end
        end
    endtask

    initial begin : watchdog
        #1500000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] pats [3];
        int ndone;
        logic [31:0] r;
        logic co;
        pats[0] = 32'h8000_0001;
        pats[1] = 32'hA5C3_0F96;
        pats[2] = 32'h1234_FEDC;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 result", result, 32'd0);
        check("R1 flags", {28'b0, carry, done, err, 1'b0}, 32'd0);

        for (int p = 0; p < 3; p++)
            for (int md = 0; md < 4; md++)
                for (int wi = 0; wi < 2; wi++)
                    for (int n = 0; n <= 34; n++)
                        do_op(md, (wi == 1) ? 32 : 16, n, pats[p]);

        @(negedge clk);
        check("R8 idle done low", {31'b0, done}, 32'd0);

        // R9: pulse mode, enable held high
        mode = 2'd0; wide = 1'b0; count = 6'd1; operand = 32'h0000_8001;
        pulse_mode = 1'b1; exec_en = 1'b1;
        ndone = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (done) ndone++;
        end
        check("R9 single execution", ndone, 32'd1);
        ref_rot(0, 16, 1, 32'h0000_8001, exp_c, r, co);
        exp_res = r; exp_c = co;
        check("R9 result", result, exp_res);
        exec_en = 1'b0;
        @(negedge clk);
        exec_en = 1'b1;
        @(negedge clk);
        check("R9 re-arm", {31'b0, done}, 32'd1);

        // R10: level mode, enable held high
        exec_en = 1'b0;
        @(negedge clk);
        pulse_mode = 1'b0; exec_en = 1'b1;
        ndone = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (done) ndone++;
        end
        check("R10 every cycle", ndone, 32'd4);
        exec_en = 1'b0;
        @(negedge clk);
        check("R10 result", result, exp_res);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule